// File: doc/BRIEF.md
# Load-Store Lane Aligner

This block sits between a 64-bit register datapath and a byte-addressed memory that has a 64-bit data bus. For every memory request it adds a sign-extended 16-bit displacement to a 64-bit base register value to form the effective address. A zero displacement gives register-indirect access. A zero base gives absolute addressing.

On a store, the block moves the low-order bytes of the register onto the byte lanes that the address selects and produces a matching byte-enable mask. On a load, it takes the memory doubleword returned in the following cycle, pulls out the addressed bytes, and extends them to 64 bits with zeros or with copies of the sign bit. Four access sizes are handled: byte, halfword, word and doubleword. A runtime input chooses big-endian or little-endian lane order. An access that is not naturally aligned raises a fault and has no effect on memory or on the register file.

Top module: `lsu_align`

## Requirements
- R1: `effAddr` equals `baseAddr` plus `dispImm` sign-extended to 64 bits, in the same cycle as the request.
- R2: `reqSize` encodes 0 = byte, 1 = halfword, 2 = word, 3 = doubleword. With `reqValid` high, `misalignFault` is high in the same cycle exactly when the access is not naturally aligned: a halfword with `effAddr[0]` set, a word with any of `effAddr[1:0]` set, or a doubleword with any of `effAddr[2:0]` set. A byte access never faults.
- R3: An aligned store drives `memByteEn` with as many contiguous ones as the access has bytes (1, 2, 4 or 8). Let o be `effAddr[2:0]` and n the byte count. With `bigEndian` = 0 the lowest enabled lane is o. With `bigEndian` = 1 it is 8 − n − o. Lane k is `memWdata[8k+7:8k]` and bit k of `memByteEn`.
- R4: On an aligned store, byte i of `storeData` (byte 0 least significant) appears on lane o + i in little-endian mode. In big-endian mode it appears on lane 7 − o − (n − 1 − i), so the register's most significant stored byte sits at the lowest address. Lanes that are not enabled carry zero.
- R5: A misaligned access forces `memByteEn` to zero. A misaligned load never produces `loadValid`.
- R6: An aligned load request in cycle N gives `loadValid` high in cycle N+1 only. `memRdata` is taken in cycle N+1, and `loadData` is assembled from the same lanes that R3 and R4 define.
- R7: With `reqUnsigned` = 0, byte, halfword and word loads fill the upper bits of `loadData` with the loaded value's most significant bit.
- R8: With `reqUnsigned` = 1, byte, halfword and word loads fill the upper bits of `loadData` with zeros.
- R9: A doubleword load ignores `reqUnsigned` and returns all 64 bits.
- R10: After reset and whenever no store is requested, `memByteEn` is zero. During reset, `loadValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A request is present this cycle |
| reqStore | input | 1 | 1 = store, 0 = load |
| reqSize | input | 2 | Access size code |
| reqUnsigned | input | 1 | Zero-extend narrow loads |
| bigEndian | input | 1 | 1 = big-endian lane order |
| baseAddr | input | 64 | Base register value |
| dispImm | input | 16 | Signed displacement |
| storeData | input | 64 | Register value to store |
| memRdata | input | 64 | Doubleword returned by memory, one cycle after a load request |
| effAddr | output | 64 | Effective address |
| memByteEn | output | 8 | Store byte-lane enables |
| memWdata | output | 64 | Store data placed on lanes |
| misalignFault | output | 1 | Access is not naturally aligned |
| loadValid | output | 1 | `loadData` is a valid writeback |
| loadData | output | 64 | Extended load result |

## Verification
Address, fault, byte-enable and store-lane results are combinational. They are due in the request cycle itself, so the driver checks them 1 ns after applying the request at the falling edge. Load results are due one cycle later. The driver pushes the expected value into a queue and presents `memRdata` at the next falling edge. A monitor samples 2 ns after every falling edge and pops one entry whenever `loadValid` is high. A `loadValid` with an empty queue, a mismatched value, or an entry left over at the end each count as a failure. This catches both late and suppressed writebacks.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam int DATA_W = 64;
  localparam int ADDR_W = 64;
  localparam int DISP_W = 16;
  localparam int LANES  = DATA_W / 8;
  localparam int LANE_W = $clog2(LANES);

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } accSize_e;

  // request-cycle strobes from control to datapath
  typedef struct packed {
    logic              storeStrobe;
    logic [LANE_W-1:0] laneBase;
    logic [LANES-1:0]  laneMask;
  } reqStrobe_t;

  // registered attributes of an accepted load
  typedef struct packed {
    logic              valid;
    logic              unsignedLd;
    accSize_e          size;
    logic [LANE_W-1:0] laneBase;
  } ldStrobe_t;
endpackage

// File: rtl/lsu_ctrl.sv
module lsu_ctrl
  import lsu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqStore,
  input  accSize_e          reqSize,
  input  logic              reqUnsigned,
  input  logic              bigEndian,
  input  logic [LANE_W-1:0] laneOffset,
  output reqStrobe_t        reqCtrl,
  output ldStrobe_t         ldCtrl,
  output logic              misalignFault
);
  logic [LANE_W-1:0] sizeMask;
  logic [LANE_W-1:0] laneBase;
  logic [LANES-1:0]  countMask;
  logic              misaligned;
  logic              loadStrobe;

  always_comb begin
    sizeMask = LANE_W'((1 << int'(reqSize)) - 1);
    for (int l = 0; l < LANES; l++) begin
      countMask[l] = (l < (1 << int'(reqSize)));
    end
  end

  assign misaligned    = |(laneOffset & sizeMask);
  assign misalignFault = reqValid && misaligned;
  // mirrored lane index for big-endian: first lane = lanes - bytes - offset
  assign laneBase      = bigEndian ? (~laneOffset & ~sizeMask) : laneOffset;
  assign loadStrobe    = reqValid && !reqStore && !misaligned;

  assign reqCtrl.storeStrobe = reqValid && reqStore && !misaligned;
  assign reqCtrl.laneBase    = laneBase;
  assign reqCtrl.laneMask    = countMask << laneBase;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ldCtrl <= '0;
    end else begin
      ldCtrl.valid      <= loadStrobe;
      ldCtrl.unsignedLd <= reqUnsigned;
      ldCtrl.size       <= reqSize;
      ldCtrl.laneBase   <= laneBase;
    end
  end

  p_fault_blocks_load_r5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqStore && misalignFault) |=> !ldCtrl.valid);

  p_byte_never_faults_r2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqSize == SZ_BYTE) |-> !misalignFault);
endmodule

// File: rtl/lsu_datapath.sv
module lsu_datapath
  import lsu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [DISP_W-1:0] dispImm,
  input  logic [DATA_W-1:0] storeData,
  input  logic [DATA_W-1:0] memRdata,
  input  reqStrobe_t        reqCtrl,
  input  ldStrobe_t         ldCtrl,
  output logic [ADDR_W-1:0] effAddr,
  output logic [LANE_W-1:0] laneOffset,
  output logic [LANES-1:0]  memByteEn,
  output logic [DATA_W-1:0] memWdata,
  output logic              loadValid,
  output logic [DATA_W-1:0] loadData
);
  logic [DATA_W-1:0] shiftedStore;
  logic [DATA_W-1:0] rawLoad;
  logic [DATA_W-1:0] extLoad;

  assign effAddr    = baseAddr + {{(ADDR_W-DISP_W){dispImm[DISP_W-1]}}, dispImm};
  assign laneOffset = effAddr[LANE_W-1:0];

  assign shiftedStore = storeData << {reqCtrl.laneBase, 3'b000};
  assign memByteEn    = reqCtrl.storeStrobe ? reqCtrl.laneMask : '0;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign memWdata[8*l +: 8] = memByteEn[l] ? shiftedStore[8*l +: 8] : 8'h00;
  end

  assign rawLoad = memRdata >> {ldCtrl.laneBase, 3'b000};

  always_comb begin
    unique case (ldCtrl.size)
      SZ_BYTE:  extLoad = {{(DATA_W-8){rawLoad[7] & ~ldCtrl.unsignedLd}},  rawLoad[7:0]};
      SZ_HALF:  extLoad = {{(DATA_W-16){rawLoad[15] & ~ldCtrl.unsignedLd}}, rawLoad[15:0]};
      SZ_WORD:  extLoad = {{(DATA_W-32){rawLoad[31] & ~ldCtrl.unsignedLd}}, rawLoad[31:0]};
      default:  extLoad = rawLoad;
    endcase
  end

  assign loadValid = ldCtrl.valid;
  assign loadData  = ldCtrl.valid ? extLoad : '0;

  p_zero_fill_byte_r8: assert property (@(posedge clk) disable iff (!rstN)
    (loadValid && ldCtrl.unsignedLd && ldCtrl.size == SZ_BYTE) |-> (loadData[DATA_W-1:8] == '0));

  p_enables_only_on_store_r10: assert property (@(posedge clk) disable iff (!rstN)
    !reqCtrl.storeStrobe |-> (memByteEn == '0 && memWdata == '0));
endmodule

// File: rtl/lsu_align.sv
module lsu_align
  import lsu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqStore,
  input  logic [1:0]        reqSize,
  input  logic              reqUnsigned,
  input  logic              bigEndian,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [DISP_W-1:0] dispImm,
  input  logic [DATA_W-1:0] storeData,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] effAddr,
  output logic [LANES-1:0]  memByteEn,
  output logic [DATA_W-1:0] memWdata,
  output logic              misalignFault,
  output logic              loadValid,
  output logic [DATA_W-1:0] loadData
);
  reqStrobe_t        reqCtrl;
  ldStrobe_t         ldCtrl;
  logic [LANE_W-1:0] laneOffset;

  lsu_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .reqStore     (reqStore),
    .reqSize      (accSize_e'(reqSize)),
    .reqUnsigned  (reqUnsigned),
    .bigEndian    (bigEndian),
    .laneOffset   (laneOffset),
    .reqCtrl      (reqCtrl),
    .ldCtrl       (ldCtrl),
    .misalignFault(misalignFault)
  );

  lsu_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .baseAddr  (baseAddr),
    .dispImm   (dispImm),
    .storeData (storeData),
    .memRdata  (memRdata),
    .reqCtrl   (reqCtrl),
    .ldCtrl    (ldCtrl),
    .effAddr   (effAddr),
    .laneOffset(laneOffset),
    .memByteEn (memByteEn),
    .memWdata  (memWdata),
    .loadValid (loadValid),
    .loadData  (loadData)
  );

  p_fault_zero_enables_r5: assert property (@(posedge clk) disable iff (!rstN)
    misalignFault |-> (memByteEn == '0));

  p_enable_count_r3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqStore && !misalignFault) |-> ($countones(memByteEn) == (1 << reqSize)));

  p_load_next_cycle_r6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqStore && !misalignFault) |=> loadValid);

  p_no_spurious_load_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && !reqStore) |=> !loadValid);
endmodule

// File: tb/sim_lsu_align.sv
module sim_lsu_align;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqStore = 1'b0;
  logic [1:0]  reqSize = 2'd0;
  logic        reqUnsigned = 1'b0;
  logic        bigEndian = 1'b0;
  logic [63:0] baseAddr = '0;
  logic [15:0] dispImm = '0;
  logic [63:0] storeData = '0;
  logic [63:0] memRdata = '0;
  logic [63:0] effAddr;
  logic [7:0]  memByteEn;
  logic [63:0] memWdata;
  logic        misalignFault;
  logic        loadValid;
  logic [63:0] loadData;

  int checks = 0;
  int failures = 0;
  logic [63:0] expQ[$];

  always #4 clk = ~clk;

  lsu_align u0 (.*);

  function automatic int laneOf(int o, int n, int i, bit be);
    return be ? (7 - o - (n - 1 - i)) : (o + i);
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one request; checks same-cycle results and queues the expected load
  task automatic access(bit st, int sz, bit uns, bit be, logic [63:0] base,
                        logic [15:0] disp, logic [63:0] data, logic [63:0] word);
    int n = 1 << sz;
    logic [63:0] ea = base + {{48{disp[15]}}, disp};
    int o = int'(ea[2:0]);
    bit flt = (o % n) != 0;
    logic [7:0]  expBe = '0;
    logic [63:0] expWd = '0;
    logic [63:0] expLd = '0;
    @(negedge clk);
    reqValid = 1'b1; reqStore = st; reqSize = 2'(sz); reqUnsigned = uns;
    bigEndian = be; baseAddr = base; dispImm = disp; storeData = data;
    #1;
    check("R1 effAddr", effAddr, ea);
    check("R2 fault", 64'(misalignFault), 64'(flt));
    if (!flt && st) begin
      for (int i = 0; i < n; i++) begin
        expBe[laneOf(o, n, i, be)] = 1'b1;
        expWd[8*laneOf(o, n, i, be) +: 8] = data[8*i +: 8];
      end
    end
    if (flt) check("R5 byteEn on fault", 64'(memByteEn), 64'(0));
    else if (st) begin
      check("R3 byteEn", 64'(memByteEn), 64'(expBe));
      check("R4 wdata", memWdata, expWd);
    end else check("R10 byteEn on load", 64'(memByteEn), 64'(0));
    if (!st && !flt) begin
      for (int i = 0; i < n; i++) expLd[8*i +: 8] = word[8*laneOf(o, n, i, be) +: 8];
      if (n < 8 && !uns && expLd[8*n-1]) begin
        for (int b = 8*n; b < 64; b++) expLd[b] = 1'b1;
      end
      expQ.push_back(expLd);
    end
    @(negedge clk);
    reqValid = 1'b0;
    memRdata = word;
  endtask

  // monitor: load results due one cycle after the request
  always @(negedge clk) begin
    #2;
    if (rstN && loadValid) begin
      if (expQ.size() == 0) begin
        checks++; failures++;
        $display("FAIL R5/R6 unexpected loadValid actual=1 expected=0");
      end else begin
        check("R6-R9 loadData", loadData, expQ.pop_front());
      end
    end
  end

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R10 reset loadValid", 64'(loadValid), 64'(0));
    check("R10 reset byteEn", 64'(memByteEn), 64'(0));
    rstN = 1'b1;
    // byte stores on every lane, both orders (R3, R4)
    for (int be = 0; be < 2; be++)
      for (int o = 0; o < 8; o++)
        access(1, 0, 0, be[0], 64'h1000 + 64'(o), 16'h0, 64'h1122334455667788, '0);
    // wider stores, aligned
    for (int be = 0; be < 2; be++) begin
      access(1, 1, 0, be[0], 64'h2000, 16'h0006, 64'hAABBCCDDEEFF0102, '0);
      access(1, 2, 0, be[0], 64'h2004, 16'h0000, 64'hAABBCCDDEEFF0102, '0);
      access(1, 2, 0, be[0], 64'h2000, 16'h0000, 64'hAABBCCDDEEFF0102, '0);
      access(1, 3, 0, be[0], 64'h2008, 16'h0000, 64'h0123456789ABCDEF, '0);
    end
    // negative displacement and absolute addressing (R1)
    access(1, 1, 0, 0, 64'h3000, 16'hFFFE, 64'h00000000000055AA, '0);
    access(1, 0, 0, 1, 64'h0, 16'h7FF3, 64'h00000000000000C3, '0);
    // misaligned stores and loads (R2, R5)
    access(1, 1, 0, 0, 64'h4001, 16'h0, 64'hFFFF, '0);
    access(1, 2, 0, 1, 64'h4002, 16'h0, 64'hFFFF, '0);
    access(1, 3, 0, 0, 64'h4004, 16'h0, 64'hFFFF, '0);
    access(0, 2, 0, 0, 64'h4006, 16'h0, '0, 64'hFFFFFFFFFFFFFFFF);
    access(0, 3, 1, 1, 64'h4001, 16'h0, '0, 64'hFFFFFFFFFFFFFFFF);
    // signed and unsigned narrow loads (R7, R8)
    for (int be = 0; be < 2; be++)
      for (int u = 0; u < 2; u++) begin
        access(0, 0, u[0], be[0], 64'h5003, 16'h0, '0, 64'h80F17E5A9C3B2D81);
        access(0, 0, u[0], be[0], 64'h5006, 16'h0, '0, 64'h80F17E5A9C3B2D81);
        access(0, 1, u[0], be[0], 64'h5002, 16'h0, '0, 64'h80F17E5A9C3B2D81);
        access(0, 1, u[0], be[0], 64'h5000, 16'h0, '0, 64'h80F17E5A9C3B2D81);
        access(0, 2, u[0], be[0], 64'h5004, 16'h0, '0, 64'h80F17E5A9C3B2D81);
        access(0, 2, u[0], be[0], 64'h5000, 16'h0, '0, 64'h80F17E5A9C3B2D81);
        // doubleword ignores unsigned control (R9)
        access(0, 3, u[0], be[0], 64'h5008, 16'h0, '0, 64'h80F17E5A9C3B2D81);
      end
    repeat (3) @(negedge clk);
    checks++;
    if (expQ.size() != 0) begin
      failures++;
      $display("FAIL R6 missing loadValid actual=%0d expected=0", expQ.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule